// File: doc/BRIEF.md
# Four-phase time-sliced buffer RAM multiplexer

This block lets three agents share one 32-bit-wide, 1280-byte buffer RAM: the USB serial engine, the ATA DMA engine and an embedded microcontroller. It does not arbitrate. A free-running 2-bit phase counter splits the 60 MHz slice clock into four slots. The USB engine, the ATA engine and the microcontroller each own one slot, so each one gets a 15 MHz window that repeats. The fourth slot never touches the RAM. In its own slot, an agent that raises its request performs exactly one word access, either a read or a write.

Every agent addresses the RAM through byte pointers held inside the block. Software or a sequencer loads each pointer, and the pointer then steps one word for every access that completes. The USB engine has one pointer for each endpoint buffer and names the active endpoint on every access. The ATA engine has one pointer for the IN buffer and one for the OUT buffer, and its direction bit picks between them. The microcontroller has a single pointer. Each byte pointer is turned into a word address for the RAM port. Read data comes back on a shared bus one cycle after the slot, with a valid strobe for the agent that made the read.

Top module: `sram_tdm_mux`

## Requirements
- R1: While reset is held, `slot` reads 0 (the USB slot), `ram_en` and `ram_we` are 0, and all three read-valid strobes are 0.
- R2: After reset, `slot` steps by one each clock in the order 0 (USB), 1 (ATA), 2 (microcontroller), 3 (idle), and then returns to 0.
- R3: In slot 3, `ram_en` and `ram_we` stay 0 whatever requests are raised, and no read-valid strobe follows.
- R4: In slot 0 with `usb_req` high, `ram_addr` equals the byte pointer of endpoint `usb_ep` divided by 4. If `usb_ep` is not below the endpoint count (5), no access happens.
- R5: In slot 1 with `ata_req` high, `ram_addr` comes from the OUT pointer when `ata_dir`=0 and from the IN pointer when `ata_dir`=1. A load with `ata_ld_sel`=0 writes the OUT pointer, and a load with `ata_ld_sel`=1 writes the IN pointer.
- R6: In slot 2 with `mcu_req` high, `ram_addr` comes from the microcontroller's own pointer.
- R7: `ram_en` and `ram_we` follow only the agent that owns the current slot. A request or write enable raised by any other agent has no effect, and its pointer does not move.
- R8: Each completed access moves the owner's pointer forward by 4 bytes. A step from byte 0x4FC wraps the pointer to 0x000. A pointer that has no access keeps its value.
- R9: A read in an agent's slot raises only that agent's read-valid strobe for the next cycle, and `rd_data` then holds the addressed word. A write raises no strobe.
- R10: Loading a pointer clears the two low byte bits. If a load and an access on the same pointer fall in the same cycle, the access uses the old value and the loaded value wins for the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz slice clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_ep | input | 3 | Endpoint the USB engine reports as active |
| usb_req | input | 1 | USB engine access request for its slot |
| usb_we | input | 1 | USB access is a write |
| usb_wdata | input | 32 | USB write word |
| usb_ld | input | 1 | Load an endpoint pointer |
| usb_ld_ep | input | 3 | Endpoint whose pointer is loaded |
| usb_ld_addr | input | 11 | Byte address to load |
| usb_rvalid | output | 1 | USB read data valid on `rd_data` |
| ata_dir | input | 1 | 0 selects the OUT pointer, 1 selects the IN pointer |
| ata_req | input | 1 | ATA engine access request |
| ata_we | input | 1 | ATA access is a write |
| ata_wdata | input | 32 | ATA write word |
| ata_ld | input | 1 | Load an ATA pointer |
| ata_ld_sel | input | 1 | 0 loads the OUT pointer, 1 loads the IN pointer |
| ata_ld_addr | input | 11 | Byte address to load |
| ata_rvalid | output | 1 | ATA read data valid |
| mcu_req | input | 1 | Microcontroller access request |
| mcu_we | input | 1 | Microcontroller access is a write |
| mcu_wdata | input | 32 | Microcontroller write word |
| mcu_ld | input | 1 | Load the microcontroller pointer |
| mcu_ld_addr | input | 11 | Byte address to load |
| mcu_rvalid | output | 1 | Microcontroller read data valid |
| rd_data | output | 32 | Shared read data bus |
| slot | output | 2 | Current slot number |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 9 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid the cycle after the access |

## Verification
The read-valid assertions take for granted that the RAM behind the port is synchronous, so that `ram_rdata` holds the word addressed in the previous cycle. They also take for granted that the request inputs are free of X, since `$onehot0` and the pointer-hold check depend on clean request and load signals. The bench models the RAM with a one-cycle read latency and drives every request, load and select at the falling edge from known values. It raises requests only in the intended slot, except in the tests that raise them on purpose in a foreign slot or in the idle slot.

// File: rtl/sram_tdm_pkg.sv
package sram_tdm_pkg;
  localparam int unsigned BUF_BYTES      = 1280;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned BYTES_PER_WORD = DATA_W / 8;
  localparam int unsigned LANE_W         = $clog2(BYTES_PER_WORD);
  localparam int unsigned BADDR_W        = $clog2(BUF_BYTES);
  localparam int unsigned WADDR_W        = BADDR_W - LANE_W;

  typedef logic [BADDR_W-1:0] baddr_t;
  typedef logic [WADDR_W-1:0] waddr_t;
  typedef logic [DATA_W-1:0]  word_t;

  typedef enum logic [1:0] {
    SLOT_USB  = 2'd0,
    SLOT_ATA  = 2'd1,
    SLOT_MCU  = 2'd2,
    SLOT_IDLE = 2'd3
  } slot_e;

  // Drop the byte-lane bits of a byte address.
  function automatic baddr_t align_byte(baddr_t a);
    return {a[BADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  endfunction

  // Word index seen by the RAM port.
  function automatic waddr_t to_word(baddr_t a);
    return a[BADDR_W-1:LANE_W];
  endfunction

  // Next word pointer, wrapping at the end of the buffer.
  function automatic baddr_t step_byte(baddr_t a);
    logic [BADDR_W:0] n;
    n = {1'b0, align_byte(a)} + (BADDR_W+1)'(BYTES_PER_WORD);
    if (n >= (BADDR_W+1)'(BUF_BYTES)) n = '0;
    return n[BADDR_W-1:0];
  endfunction
endpackage

// File: rtl/tdm_phase_gen.sv
module tdm_phase_gen
  import sram_tdm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_e slot
);
  logic [1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 2'd0;
    else        phase_q <= phase_q + 2'd1;
  end

  assign slot = slot_e'(phase_q);

  // R2
  idle_then_usb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slot) == SLOT_IDLE) |-> (slot == SLOT_USB));
endmodule

// File: rtl/addr_ptr_bank.sv
module addr_ptr_bank
  import sram_tdm_pkg::*;
#(
  parameter int unsigned N     = 2,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld,
  input  logic [IDX_W-1:0]           ld_idx,
  input  baddr_t                     ld_val,
  input  logic                       adv,
  input  logic [IDX_W-1:0]           adv_idx,
  output logic [N-1:0][BADDR_W-1:0]  q
);
  logic [N-1:0] ld_hit;
  logic [N-1:0] adv_hit;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ld_hit[i]  = ld  && (int'(ld_idx)  == i);
      adv_hit[i] = adv && (int'(adv_idx) == i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ld_hit[i])       q[i] <= align_byte(ld_val);
        else if (adv_hit[i]) q[i] <= step_byte(q[i]);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_hit[g] && !adv_hit[g]) |=> $stable(q[g]));
  end
endmodule

// File: rtl/tdm_slot_mux.sv
module tdm_slot_mux
  import sram_tdm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  slot_e  slot,
  input  logic   usb_req,
  input  logic   usb_ok,
  input  logic   usb_we,
  input  word_t  usb_wdata,
  input  baddr_t usb_addr,
  input  logic   ata_req,
  input  logic   ata_we,
  input  word_t  ata_wdata,
  input  baddr_t ata_addr,
  input  logic   mcu_req,
  input  logic   mcu_we,
  input  word_t  mcu_wdata,
  input  baddr_t mcu_addr,
  output logic   usb_hit,
  output logic   ata_hit,
  output logic   mcu_hit,
  output logic   ram_en,
  output logic   ram_we,
  output waddr_t ram_addr,
  output word_t  ram_wdata,
  output logic   usb_rvalid,
  output logic   ata_rvalid,
  output logic   mcu_rvalid
);
  assign usb_hit = (slot == SLOT_USB) && usb_req && usb_ok;
  assign ata_hit = (slot == SLOT_ATA) && ata_req;
  assign mcu_hit = (slot == SLOT_MCU) && mcu_req;

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    unique case (slot)
      SLOT_USB: begin
        ram_en    = usb_hit;
        ram_we    = usb_hit && usb_we;
        ram_addr  = to_word(usb_addr);
        ram_wdata = usb_wdata;
      end
      SLOT_ATA: begin
        ram_en    = ata_hit;
        ram_we    = ata_hit && ata_we;
        ram_addr  = to_word(ata_addr);
        ram_wdata = ata_wdata;
      end
      SLOT_MCU: begin
        ram_en    = mcu_hit;
        ram_we    = mcu_hit && mcu_we;
        ram_addr  = to_word(mcu_addr);
        ram_wdata = mcu_wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usb_rvalid <= 1'b0;
      ata_rvalid <= 1'b0;
      mcu_rvalid <= 1'b0;
    end else begin
      usb_rvalid <= usb_hit && !usb_we;
      ata_rvalid <= ata_hit && !ata_we;
      mcu_rvalid <= mcu_hit && !mcu_we;
    end
  end

  // R7
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_en);

  // R9
  rvalid_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({usb_rvalid, ata_rvalid, mcu_rvalid}));

  // R9
  usb_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_rvalid |-> $past(ram_en && !ram_we && slot == SLOT_USB));

  // R9
  mcu_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_rvalid |-> $past(ram_en && !ram_we && slot == SLOT_MCU));
endmodule

// File: rtl/sram_tdm_mux.sv
module sram_tdm_mux
  import sram_tdm_pkg::*;
#(
  parameter int unsigned NUM_EP = 5,
  parameter int unsigned EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EP_W-1:0]    usb_ep,
  input  logic               usb_req,
  input  logic               usb_we,
  input  logic [DATA_W-1:0]  usb_wdata,
  input  logic               usb_ld,
  input  logic [EP_W-1:0]    usb_ld_ep,
  input  logic [BADDR_W-1:0] usb_ld_addr,
  output logic               usb_rvalid,
  input  logic               ata_dir,
  input  logic               ata_req,
  input  logic               ata_we,
  input  logic [DATA_W-1:0]  ata_wdata,
  input  logic               ata_ld,
  input  logic               ata_ld_sel,
  input  logic [BADDR_W-1:0] ata_ld_addr,
  output logic               ata_rvalid,
  input  logic               mcu_req,
  input  logic               mcu_we,
  input  logic [DATA_W-1:0]  mcu_wdata,
  input  logic               mcu_ld,
  input  logic [BADDR_W-1:0] mcu_ld_addr,
  output logic               mcu_rvalid,
  output logic [DATA_W-1:0]  rd_data,
  output logic [1:0]         slot,
  output logic               ram_en,
  output logic               ram_we,
  output logic [WADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata
);
  slot_e slot_now;
  logic  usb_hit, ata_hit, mcu_hit;
  logic  usb_ep_ok;
  logic [EP_W-1:0] usb_idx;

  logic [NUM_EP-1:0][BADDR_W-1:0] usb_ptr;
  logic [1:0][BADDR_W-1:0]        ata_ptr;
  logic [0:0][BADDR_W-1:0]        mcu_ptr;

  tdm_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (slot_now)
  );

  assign slot      = slot_now;
  assign usb_ep_ok = int'(usb_ep) < NUM_EP;
  assign usb_idx   = usb_ep_ok ? usb_ep : '0;

  addr_ptr_bank #(.N(NUM_EP), .IDX_W(EP_W)) u_usb_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (usb_ld),
    .ld_idx  (usb_ld_ep),
    .ld_val  (usb_ld_addr),
    .adv     (usb_hit),
    .adv_idx (usb_idx),
    .q       (usb_ptr)
  );

  addr_ptr_bank #(.N(2), .IDX_W(1)) u_ata_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ata_ld),
    .ld_idx  (ata_ld_sel),
    .ld_val  (ata_ld_addr),
    .adv     (ata_hit),
    .adv_idx (ata_dir),
    .q       (ata_ptr)
  );

  addr_ptr_bank #(.N(1), .IDX_W(1)) u_mcu_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (mcu_ld),
    .ld_idx  (1'b0),
    .ld_val  (mcu_ld_addr),
    .adv     (mcu_hit),
    .adv_idx (1'b0),
    .q       (mcu_ptr)
  );

  tdm_slot_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot       (slot_now),
    .usb_req    (usb_req),
    .usb_ok     (usb_ep_ok),
    .usb_we     (usb_we),
    .usb_wdata  (usb_wdata),
    .usb_addr   (usb_ptr[usb_idx]),
    .ata_req    (ata_req),
    .ata_we     (ata_we),
    .ata_wdata  (ata_wdata),
    .ata_addr   (ata_ptr[ata_dir]),
    .mcu_req    (mcu_req),
    .mcu_we     (mcu_we),
    .mcu_wdata  (mcu_wdata),
    .mcu_addr   (mcu_ptr[0]),
    .usb_hit    (usb_hit),
    .ata_hit    (ata_hit),
    .mcu_hit    (mcu_hit),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .usb_rvalid (usb_rvalid),
    .ata_rvalid (ata_rvalid),
    .mcu_rvalid (mcu_rvalid)
  );

  assign rd_data = ram_rdata;

  // R3
  idle_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_now == SLOT_IDLE) |-> !ram_en);

  // R4
  usb_bad_ep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_now == SLOT_USB && !usb_ep_ok) |-> !ram_en);
endmodule

// File: tb/sram_tdm_mux_bench.sv
module sram_tdm_mux_bench;
  localparam int WORDS = 320;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  usb_ep = '0, usb_ld_ep = '0;
  logic        usb_req = 0, usb_we = 0, usb_ld = 0;
  logic [31:0] usb_wdata = '0, ata_wdata = '0, mcu_wdata = '0;
  logic [10:0] usb_ld_addr = '0, ata_ld_addr = '0, mcu_ld_addr = '0;
  logic        ata_dir = 0, ata_req = 0, ata_we = 0, ata_ld = 0, ata_ld_sel = 0;
  logic        mcu_req = 0, mcu_we = 0, mcu_ld = 0;
  logic        usb_rvalid, ata_rvalid, mcu_rvalid;
  logic [31:0] rd_data, ram_wdata;
  logic [31:0] ram_rdata = '0;
  logic [1:0]  slot;
  logic        ram_en, ram_we;
  logic [8:0]  ram_addr;

  logic [31:0] mem [WORDS];

  int checks = 0;
  int errors = 0;

  logic        s_en, s_we;
  logic [8:0]  s_addr;
  logic [31:0] s_wd, s_rd;
  logic [2:0]  s_rv;

  always #2 clk = ~clk;

  initial for (int i = 0; i < WORDS; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  sram_tdm_mux u_sram_tdm_mux (
    .clk(clk), .rst_n(rst_n),
    .usb_ep(usb_ep), .usb_req(usb_req), .usb_we(usb_we), .usb_wdata(usb_wdata),
    .usb_ld(usb_ld), .usb_ld_ep(usb_ld_ep), .usb_ld_addr(usb_ld_addr),
    .usb_rvalid(usb_rvalid),
    .ata_dir(ata_dir), .ata_req(ata_req), .ata_we(ata_we), .ata_wdata(ata_wdata),
    .ata_ld(ata_ld), .ata_ld_sel(ata_ld_sel), .ata_ld_addr(ata_ld_addr),
    .ata_rvalid(ata_rvalid),
    .mcu_req(mcu_req), .mcu_we(mcu_we), .mcu_wdata(mcu_wdata),
    .mcu_ld(mcu_ld), .mcu_ld_addr(mcu_ld_addr), .mcu_rvalid(mcu_rvalid),
    .rd_data(rd_data), .slot(slot), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // Vector: {kind[1:0], sel[2:0], byte_addr[10:0], data[31:0]}
  // kind 0 = USB (sel = endpoint), 1 = ATA (sel[0] = direction), 2 = microcontroller
  localparam logic [47:0] VEC [7] = '{
    {2'd0, 3'd0, 11'h000, 32'hA5A5_0001},
    {2'd0, 3'd1, 11'h040, 32'h1234_5678},
    {2'd0, 3'd3, 11'h0C0, 32'hDEAD_BEEF},
    {2'd0, 3'd4, 11'h100, 32'h0BAD_F00D},
    {2'd1, 3'd0, 11'h200, 32'hCAFE_0002},
    {2'd1, 3'd1, 11'h300, 32'h5555_AAAA},
    {2'd2, 3'd0, 11'h4F0, 32'h0F0F_F0F0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic go_slot(input logic [1:0] s);
    @(negedge clk);
    while (slot != s) @(negedge clk);
  endtask

  task automatic drop_all();
    usb_req = 0; usb_we = 0; ata_req = 0; ata_we = 0; mcu_req = 0; mcu_we = 0;
    mcu_ld = 0;
  endtask

  task automatic access(input int kind, input logic we, input logic [31:0] d);
    go_slot(2'(kind));
    case (kind)
      0: begin usb_req = 1; usb_we = we; usb_wdata = d; end
      1: begin ata_req = 1; ata_we = we; ata_wdata = d; end
      default: begin mcu_req = 1; mcu_we = we; mcu_wdata = d; end
    endcase
    #1;
    s_en = ram_en; s_we = ram_we; s_addr = ram_addr; s_wd = ram_wdata;
    @(negedge clk);
    drop_all();
    #1;
    s_rv = {usb_rvalid, ata_rvalid, mcu_rvalid};
    s_rd = rd_data;
  endtask

  task automatic load_ptr(input int kind, input logic [2:0] sel, input logic [10:0] a);
    @(negedge clk);
    case (kind)
      0: begin usb_ld = 1; usb_ld_ep = sel; usb_ld_addr = a; end
      1: begin ata_ld = 1; ata_ld_sel = sel[0]; ata_ld_addr = a; end
      default: begin mcu_ld = 1; mcu_ld_addr = a; end
    endcase
    @(negedge clk);
    usb_ld = 0; ata_ld = 0; mcu_ld = 0;
  endtask

  function automatic logic [2:0] rv_tag(input int kind);
    return (kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001;
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 slot", {30'd0, slot}, 32'd0);
    chk("R1 ram_en/we", {30'd0, ram_en, ram_we}, 32'd0);
    chk("R1 rvalid", {29'd0, usb_rvalid, ata_rvalid, mcu_rvalid}, 32'd0);
    rst_n = 1'b1;

    // R2: rotation 0,1,2,3,0...
    for (int i = 0; i < 8; i++) begin
      chk("R2 slot order", {30'd0, slot}, i % 4);
      @(negedge clk);
    end

    // Vector walk: write via owner, read next word, read back through microcontroller
    for (int v = 0; v < 7; v++) begin
      int          kind;
      logic [2:0]  sel;
      logic [10:0] ba;
      logic [31:0] d;
      kind = int'(VEC[v][47:46]);
      sel  = VEC[v][45:43];
      ba   = VEC[v][42:32];
      d    = VEC[v][31:0];
      usb_ep  = sel;
      ata_dir = sel[0];
      load_ptr(kind, sel, ba);
      access(kind, 1'b1, d);
      // R4 R5 R6: slot address from the owner's selected pointer
      chk("R4/R5/R6 write addr", {23'd0, s_addr}, {23'd0, ba[10:2]});
      chk("R7 write enable", {30'd0, s_en, s_we}, 32'd3);
      chk("R7 write data", s_wd, d);
      chk("R9 no strobe on write", {29'd0, s_rv}, 32'd0);
      access(kind, 1'b0, 32'd0);
      // R8: pointer moved one word
      chk("R8 step addr", {23'd0, s_addr}, {23'd0, ba[10:2]} + 32'd1);
      chk("R9 read tag", {29'd0, s_rv}, {29'd0, rv_tag(kind)});
      load_ptr(2, 3'd0, ba);
      access(2, 1'b0, 32'd0);
      chk("R9 read tag mcu", {29'd0, s_rv}, 32'd1);
      chk("R9 read data", s_rd, d);
    end

    // R5: each direction keeps its own pointer (IN advanced to 0x308, OUT to 0x208)
    ata_dir = 1'b0;
    access(1, 1'b0, 32'd0);
    chk("R5 OUT pointer", {23'd0, s_addr}, 32'h208 >> 2);
    ata_dir = 1'b1;
    access(1, 1'b0, 32'd0);
    chk("R5 IN pointer", {23'd0, s_addr}, 32'h308 >> 2);

    // R3 + R8: idle slot ignores all requests, pointers hold
    load_ptr(2, 3'd0, 11'h010);
    go_slot(2'd3);
    usb_ep = 3'd0; usb_req = 1; usb_we = 1; ata_req = 1; ata_we = 1; mcu_req = 1; mcu_we = 1;
    #1;
    chk("R3 idle ram_en/we", {30'd0, ram_en, ram_we}, 32'd0);
    @(negedge clk);
    drop_all();
    #1;
    chk("R3 idle no strobe", {29'd0, usb_rvalid, ata_rvalid, mcu_rvalid}, 32'd0);
    access(2, 1'b0, 32'd0);
    chk("R8 hold without access", {23'd0, s_addr}, 32'h010 >> 2);

    // R7: foreign requests in USB slot have no effect
    load_ptr(2, 3'd0, 11'h020);
    go_slot(2'd0);
    ata_req = 1; ata_we = 1; mcu_req = 1; mcu_we = 1;
    #1;
    chk("R7 foreign request", {30'd0, ram_en, ram_we}, 32'd0);
    @(negedge clk);
    drop_all();
    access(2, 1'b0, 32'd0);
    chk("R7 foreign pointer unmoved", {23'd0, s_addr}, 32'h020 >> 2);

    // R4: out-of-range endpoint is refused
    usb_ep = 3'd6;
    access(0, 1'b1, 32'h1111_2222);
    chk("R4 bad endpoint", {31'd0, s_en}, 32'd0);
    usb_ep = 3'd0;

    // R8: wrap at end of buffer
    load_ptr(2, 3'd0, 11'h4FC);
    access(2, 1'b0, 32'd0);
    chk("R8 last word", {23'd0, s_addr}, 32'h4FC >> 2);
    access(2, 1'b0, 32'd0);
    chk("R8 wrap", {23'd0, s_addr}, 32'd0);

    // R10: low bits cleared on load
    load_ptr(2, 3'd0, 11'h023);
    access(2, 1'b0, 32'd0);
    chk("R10 alignment", {23'd0, s_addr}, 32'h020 >> 2);

    // R10: load and access together; access uses old, load wins next
    go_slot(2'd2);
    mcu_req = 1; mcu_ld = 1; mcu_ld_addr = 11'h080;
    #1;
    chk("R10 old pointer used", {23'd0, ram_addr}, 32'h024 >> 2);
    @(negedge clk);
    drop_all();
    access(2, 1'b0, 32'd0);
    chk("R10 load wins", {23'd0, s_addr}, 32'h080 >> 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule